// File: doc/BRIEF.md
# Hamming Single-Error Corrector

This block protects a data word with a single-error-correcting Hamming code. Its encoding half takes a data word (8 bits by default) and produces a codeword (12 bits by default). In that codeword, check bits sit at every power-of-two position, counting positions from 1. Data bits fill the remaining positions in ascending order. Each check bit makes its covered group even.

The decoding half takes a received codeword and recomputes every check group. The failing groups form a syndrome whose value is the 1-based position of a single flipped bit. The decoder inverts that bit and returns the repaired data word, together with the syndrome and two status flags. Syndrome values above the codeword length cannot come from one flipped bit, so they are reported as uncorrectable.

Both halves are pure logic. A parameter selects whether the outputs pass through one register stage. With the default, that stage is present and is cleared by an asynchronous active-low reset. The check-bit count is derived from the data width as the smallest K with 2^K − 1 ≥ data width + K.

Top module: `hsec_codec`

## Requirements
- R1: Codeword bit p-1 carries position p. With the default width, data bit `enc_data_in[k]` lands at the (k+1)-th non-power-of-two position: bits 0..7 go to positions 3, 5, 6, 7, 9, 10, 11, 12.
- R2: The bit at position 2^j equals the XOR of all data positions whose index has bit j set, so every covered group has even parity. Data 8'h4D encodes to 12'h4E5.
- R3: A received word with no error gives syndrome 0, both flags low, and the data bits of the word on `dec_data_out`.
- R4: A single flipped data position p gives `dec_syndrome` = p, `dec_corrected` high, `dec_uncorrectable` low, and the original data word.
- R5: A single flipped check position (1, 2, 4 or 8) gives syndrome equal to that position and `dec_corrected` high, and leaves `dec_data_out` equal to the original data.
- R6: A syndrome of 13, 14 or 15 raises `dec_uncorrectable`, keeps `dec_corrected` low, and passes the received data positions through unchanged.
- R7: With REG_OUT = 1, every output changes one clock after its input. While `rst_n` is low, every output reads zero.
- R8: Received word 12'h6E5, which is 12'h4E5 with position 10 flipped, decodes to syndrome 10 and data 8'h4D.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Asynchronous active-low reset of the output stage |
| enc_data_in | input | 8 | Data word to encode |
| enc_code_out | output | 12 | Encoded word, bit p-1 = position p |
| dec_code_in | input | 12 | Received word to check and repair |
| dec_data_out | output | 8 | Repaired data word |
| dec_corrected | output | 1 | A single-bit repair was applied |
| dec_uncorrectable | output | 1 | Syndrome points beyond the codeword |
| dec_syndrome | output | 4 | Recomputed check result, 1-based error position |

## Verification
The flag assertions assume that the syndrome is the only thing that decides the status: they hold for any received word, so the stimulus may be arbitrary. The stability assertions assume that the output stage was not held in reset on the previous edge. The stimulus changes inputs only on falling edges, after reset has been released. All stimuli are valid codewords, single-bit flips of them, or two-bit flips chosen so that the flipped positions XOR to 13, 14 or 15. Double flips whose positions XOR to a legal position would be miscorrected by design, so they are never driven.

// File: rtl/hsec_pkg.sv
package hsec_pkg;

   function automatic bit is_pow2(int p);
      return (p > 0) && ((p & (p - 1)) == 0);
   endfunction

   // smallest K with 2^K - 1 >= m + K
   function automatic int chk_w(int m);
      for (int k = 1; k < 16; k++) begin
         if (((1 << k) - 1) >= (m + k)) return k;
      end
      return 16;
   endfunction

   // 1-based codeword position of data bit k (0-based)
   function automatic int data_pos(int k);
      int cnt;
      cnt = 0;
      for (int p = 1; p < 128; p++) begin
         if (!is_pow2(p)) begin
            if (cnt == k) return p;
            cnt++;
         end
      end
      return 0;
   endfunction

   // data index held by a non-power-of-two position p
   function automatic int data_idx(int p);
      int cnt;
      cnt = 0;
      for (int q = 1; q < p; q++) begin
         if (!is_pow2(q)) cnt++;
      end
      return cnt;
   endfunction

endpackage

// File: rtl/hsec_enc.sv
module hsec_enc #(
   parameter int DATA_W = 8,
   localparam int CHK_W = hsec_pkg::chk_w(DATA_W),
   localparam int CODE_W = DATA_W + CHK_W
) (
   input  logic [DATA_W-1:0] data_i,
   output logic [CODE_W-1:0] code_o
);

   for (genvar p = 1; p <= CODE_W; p++) begin : g_pos
      if (hsec_pkg::is_pow2(p)) begin : g_chk
         logic par;
         always_comb begin
            par = 1'b0;
            for (int k = 0; k < DATA_W; k++) begin
               if ((hsec_pkg::data_pos(k) & p) != 0) par = par ^ data_i[k];
            end
         end
         assign code_o[p-1] = par;
      end else begin : g_dat
         assign code_o[p-1] = data_i[hsec_pkg::data_idx(p)];
      end
   end

endmodule

// File: rtl/hsec_syn.sv
module hsec_syn #(
   parameter int DATA_W = 8,
   localparam int CHK_W = hsec_pkg::chk_w(DATA_W),
   localparam int CODE_W = DATA_W + CHK_W
) (
   input  logic [CODE_W-1:0] code_i,
   output logic [CHK_W-1:0]  syn_o
);

   for (genvar j = 0; j < CHK_W; j++) begin : g_grp
      logic acc;
      always_comb begin
         acc = 1'b0;
         for (int p = 1; p <= CODE_W; p++) begin
            if (((p >> j) & 1) != 0) acc = acc ^ code_i[p-1];
         end
      end
      assign syn_o[j] = acc;
   end

endmodule

// File: rtl/hsec_dec.sv
module hsec_dec #(
   parameter int DATA_W = 8,
   localparam int CHK_W = hsec_pkg::chk_w(DATA_W),
   localparam int CODE_W = DATA_W + CHK_W
) (
   input  logic [CODE_W-1:0] code_i,
   output logic [DATA_W-1:0] data_o,
   output logic              corrected_o,
   output logic              uncorr_o,
   output logic [CHK_W-1:0]  syn_o
);

   logic [CHK_W-1:0]  syn;
   logic [CODE_W-1:0] fixed;

   hsec_syn #(.DATA_W(DATA_W)) syn_i (
      .code_i (code_i),
      .syn_o  (syn)
   );

   // a syndrome beyond CODE_W matches no position, so nothing is flipped
   for (genvar p = 1; p <= CODE_W; p++) begin : g_fix
      assign fixed[p-1] = code_i[p-1] ^ (syn == CHK_W'(p));
   end

   for (genvar k = 0; k < DATA_W; k++) begin : g_ext
      assign data_o[k] = fixed[hsec_pkg::data_pos(k) - 1];
   end

   assign corrected_o = (syn != '0) && (int'(syn) <= CODE_W);
   assign uncorr_o    = int'(syn) > CODE_W;
   assign syn_o       = syn;

endmodule

// File: rtl/hsec_codec.sv
module hsec_codec #(
   parameter int DATA_W = 8,
   parameter bit REG_OUT = 1'b1,
   localparam int CHK_W = hsec_pkg::chk_w(DATA_W),
   localparam int CODE_W = DATA_W + CHK_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] enc_data_in,
   output logic [CODE_W-1:0] enc_code_out,
   input  logic [CODE_W-1:0] dec_code_in,
   output logic [DATA_W-1:0] dec_data_out,
   output logic              dec_corrected,
   output logic              dec_uncorrectable,
   output logic [CHK_W-1:0]  dec_syndrome
);

   if (DATA_W < 1 || DATA_W > 57) begin : g_bad_width
      $error("hsec_codec: DATA_W must lie in 1..57");
   end

   logic [CODE_W-1:0] enc_c;
   logic [DATA_W-1:0] dat_c;
   logic              cor_c;
   logic              unc_c;
   logic [CHK_W-1:0]  syn_c;

   hsec_enc #(.DATA_W(DATA_W)) enc_i (
      .data_i (enc_data_in),
      .code_o (enc_c)
   );

   hsec_dec #(.DATA_W(DATA_W)) dec_i (
      .code_i      (dec_code_in),
      .data_o      (dat_c),
      .corrected_o (cor_c),
      .uncorr_o    (unc_c),
      .syn_o       (syn_c)
   );

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            enc_code_out      <= '0;
            dec_data_out      <= '0;
            dec_corrected     <= 1'b0;
            dec_uncorrectable <= 1'b0;
            dec_syndrome      <= '0;
         end else begin
            enc_code_out      <= enc_c;
            dec_data_out      <= dat_c;
            dec_corrected     <= cor_c;
            dec_uncorrectable <= unc_c;
            dec_syndrome      <= syn_c;
         end
      end

      // R7
      dec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(rst_n) && $stable(dec_code_in)) |=> $stable(dec_data_out));

      // R7
      enc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(rst_n) && $stable(enc_data_in)) |=> $stable(enc_code_out));
   end else begin : g_comb
      assign enc_code_out      = enc_c;
      assign dec_data_out      = dat_c;
      assign dec_corrected     = cor_c;
      assign dec_uncorrectable = unc_c;
      assign dec_syndrome      = syn_c;
   end

   // R3
   zero_syn_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_syndrome == '0) |-> (!dec_corrected && !dec_uncorrectable));

   // R4
   in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((dec_syndrome != '0) && (int'(dec_syndrome) <= CODE_W))
         |-> (dec_corrected && !dec_uncorrectable));

   // R6
   out_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(dec_syndrome) > CODE_W) |-> (dec_uncorrectable && !dec_corrected));

endmodule

// File: tb/hsec_codec_tb.sv
module hsec_codec_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  enc_data_in = '0;
   logic [11:0] enc_code_out;
   logic [11:0] dec_code_in = '0;
   logic [7:0]  dec_data_out;
   logic        dec_corrected;
   logic        dec_uncorrectable;
   logic [3:0]  dec_syndrome;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   hsec_codec dut_i (
      .clk               (clk),
      .rst_n             (rst_n),
      .enc_data_in       (enc_data_in),
      .enc_code_out      (enc_code_out),
      .dec_code_in       (dec_code_in),
      .dec_data_out      (dec_data_out),
      .dec_corrected     (dec_corrected),
      .dec_uncorrectable (dec_uncorrectable),
      .dec_syndrome      (dec_syndrome)
   );

   function automatic bit pw2(int p);
      return (p & (p - 1)) == 0;
   endfunction

   function automatic logic [11:0] ref_encode(logic [7:0] d);
      logic [11:0] c;
      int n;
      c = '0;
      n = 0;
      for (int p = 1; p <= 12; p++) begin
         if (!pw2(p)) begin
            c[p-1] = d[n];
            n++;
         end
      end
      for (int j = 0; j < 4; j++) begin
         logic par;
         par = 1'b0;
         for (int p = 1; p <= 12; p++) begin
            if (((p >> j) & 1) != 0) par = par ^ c[p-1];
         end
         c[(1 << j) - 1] = par;
      end
      return c;
   endfunction

   function automatic logic [7:0] ref_extract(logic [11:0] c);
      logic [7:0] d;
      int n;
      d = '0;
      n = 0;
      for (int p = 1; p <= 12; p++) begin
         if (!pw2(p)) begin
            d[n] = c[p-1];
            n++;
         end
      end
      return d;
   endfunction

   // syndrome as XOR of the indices of all set positions
   function automatic int ref_syn(logic [11:0] c);
      int s;
      s = 0;
      for (int p = 1; p <= 12; p++) begin
         if (c[p-1]) s = s ^ p;
      end
      return s;
   endfunction

   task automatic chk(string tag, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   // drive at a falling edge, sample at the next falling edge
   task automatic apply(logic [7:0] d, logic [11:0] c);
      enc_data_in = d;
      dec_code_in = c;
      @(negedge clk);
   endtask

   task automatic chk_dec(string tag, int syn, int cor, int unc, logic [7:0] dat);
      chk(tag, "syndrome", int'(dec_syndrome), syn);
      chk(tag, "corrected", int'(dec_corrected), cor);
      chk(tag, "uncorrectable", int'(dec_uncorrectable), unc);
      chk(tag, "data", int'(dec_data_out), int'(dat));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      enc_data_in = 8'hFF;
      dec_code_in = 12'hFFF;
      @(negedge clk);
      // R7: reset holds every output at zero
      chk("R7", "enc reset", int'(enc_code_out), 0);
      chk_dec("R7", 0, 0, 0, 8'h00);
      rst_n = 1'b1;

      // R2 / R8: worked example
      apply(8'h4D, 12'h4E5);
      chk("R2", "example code", int'(enc_code_out), 'h4E5);
      chk_dec("R3", 0, 0, 0, 8'h4D);
      apply(8'h4D, 12'h6E5);
      chk_dec("R8", 10, 1, 0, 8'h4D);

      // R7: one cycle latency after an input change
      enc_data_in = 8'hA5;
      dec_code_in = ref_encode(8'hA5) ^ 12'h010;
      @(posedge clk);
      #1;
      chk("R7", "enc latency", int'(enc_code_out), int'(ref_encode(8'hA5)));
      chk("R7", "dec latency", int'(dec_syndrome), 5);
      @(negedge clk);

      for (int b = 0; b < 256; b++) begin
         logic [11:0] cw;
         cw = ref_encode(b[7:0]);
         apply(b[7:0], cw);
         // R1: data positions carry the data bits in order
         chk("R1", "data placement", int'(ref_extract(enc_code_out)), b);
         // R2: even parity over every group
         chk("R2", "code", int'(enc_code_out), int'(cw));
         chk_dec("R3", 0, 0, 0, b[7:0]);
         for (int p = 1; p <= 12; p++) begin
            apply(b[7:0], cw ^ (12'h001 << (p - 1)));
            if (pw2(p)) chk_dec("R5", p, 1, 0, b[7:0]);
            else        chk_dec("R4", p, 1, 0, b[7:0]);
         end
         // R6: double flips whose positions XOR to 13, 14, 15
         for (int q = 1; q <= 3; q++) begin
            logic [11:0] bad;
            bad = cw ^ (12'h001 << (q - 1)) ^ 12'h800;
            apply(b[7:0], bad);
            chk_dec("R6", ref_syn(bad), 0, 1, ref_extract(bad));
         end
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule